// File: doc/BRIEF.md
# H-Bridge Switch Control Decoder

This block drives the four switch enables of a two-leg H-bridge: high side and low side of leg 1, and high side and low side of leg 2. It takes three asynchronous pins (disable, PWM and direction) and turns them into forward, reverse, high-side freewheel or all-off states. A register interface can take over control of the bridge. Protection logic elsewhere in the chip can force switches off through two chopper requests and one global shutdown request.

The three pins pass through two-flop synchronizers. The disable pin also passes through a glitch filter whose window, `FILT_CYC`, is set in clock cycles. A register write holds three command bits (enable, direction and PWM) and a request to enter register control. The block accepts that request only while all three pins are low. Any later movement on a pin cancels register control. Every switch enable comes from a flop, so protection requests act on the first clock edge after they are sampled.

Top module: `hbridge_switch_ctrl`

## Requirements
- R1: While the filtered disable pin is high and register control is off, all four switch enables are 0.
- R2: With the bridge enabled and PWM high, direction 1 turns on exactly high side 1 and low side 2. Direction 0 turns on exactly low side 1 and high side 2.
- R3: With the bridge enabled and PWM low, direction 1 turns on only high side 1 and direction 0 turns on only high side 2.
- R4: A write with `cfg_spi_mode`=1 sets `spi_mode_o` only if the synchronized disable, PWM and direction pins are all 0 at that clock edge. Otherwise `spi_mode_o` stays 0.
- R5: When the filtered disable pin, the synchronized PWM pin or the synchronized direction pin changes value, `spi_mode_o` goes to 0 and the pins control the bridge again.
- R6: While `spi_mode_o`=1, the stored bits `cfg_enable` (1 = on), `cfg_dir` and `cfg_pwm` take the place of the inverted disable pin, the direction pin and the PWM pin in R1 to R3.
- R7: `chop_hs1`=1 forces low side 2 off and `chop_hs2`=1 forces low side 1 off. Each takes effect on the next clock edge, and the other switches keep their R1 to R3 values.
- R8: `fault_off`=1 forces all four enables to 0 on the next clock edge, in both pin control and register control.
- R9: Disable pulses shorter than `FILT_CYC` cycles have no effect on the outputs. Pulses of `FILT_CYC` cycles or longer turn the bridge off.
- R10: The high-side and low-side enables of the same leg are never 1 together.
- R11: During and directly after reset, all four enables and `spi_mode_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_dis | input | 1 | Asynchronous disable pin, high = bridge off |
| pin_pwm | input | 1 | Asynchronous PWM pin |
| pin_dir | input | 1 | Asynchronous direction pin |
| cfg_wr | input | 1 | One-cycle register write strobe |
| cfg_spi_mode | input | 1 | Write data: request register control |
| cfg_enable | input | 1 | Write data: enable in register control |
| cfg_dir | input | 1 | Write data: direction in register control |
| cfg_pwm | input | 1 | Write data: PWM in register control |
| chop_hs1 | input | 1 | Current limit on high side 1, drop low side 2 |
| chop_hs2 | input | 1 | Current limit on high side 2, drop low side 1 |
| fault_off | input | 1 | Latched fault, all switches off |
| hs1_on | output | 1 | High side 1 enable |
| ls1_on | output | 1 | Low side 1 enable |
| hs2_on | output | 1 | High side 2 enable |
| ls2_on | output | 1 | Low side 2 enable |
| spi_mode_o | output | 1 | Register control active |

## Verification
The assertions assume that `chop_hs1`, `chop_hs2`, `fault_off` and the write port are synchronous to `clk`. They make no assumption about the pins, which may move at any time, because they are checked only after the synchronizers and the filter. The bench changes the synchronous inputs on falling edges. It lets the pins settle for well over the synchronizer and filter latency before it samples, except in the pulse-width tests, where the pulse length in cycles is the quantity under test.

// File: rtl/hb_pkg.sv
// Package: shared command and switch types for the H-bridge decoder.
// Assumes one enable/direction/PWM triple selects the bridge state.
package hb_pkg;

    typedef struct packed {
        logic en;
        logic dir;
        logic pwm;
    } hb_cmd_t;

    typedef struct packed {
        logic hs1;
        logic ls1;
        logic hs2;
        logic ls2;
    } hb_sw_t;

    localparam hb_sw_t SW_ALL_OFF = '0;

    // Bridge truth table: off, drive in either direction, or high-side freewheel.
    function automatic hb_sw_t hb_truth(input hb_cmd_t c);
        hb_sw_t s;
        s = SW_ALL_OFF;
        if (c.en) begin
            if (c.pwm) begin
                s.hs1 = c.dir;
                s.ls2 = c.dir;
                s.ls1 = !c.dir;
                s.hs2 = !c.dir;
            end else begin
                s.hs1 = c.dir;
                s.hs2 = !c.dir;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/hb_pin_sync.sv
// Module: two-flop synchronizer bank for asynchronous pins.
// Assumes each bit is independent; RST_VAL gives the safe value held in reset.
module hb_pin_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic sync_q;

        // Two-stage capture of one pin bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                sync_q <= RST_VAL[b];
            end else begin
                meta_q <= d_async[b];
                sync_q <= meta_q;
            end
        end

        assign q_sync[b] = sync_q;
    end

endmodule

// File: rtl/hb_glitch_filter.sv
// Module: single-bit filter that accepts a new level only after it has
// held for FILT_CYC consecutive cycles. Assumes a synchronized input.
module hb_glitch_filter #(
    parameter int   FILT_CYC = 8,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    localparam int             CW   = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0]  LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          filt_q;

    // Count cycles of disagreement; adopt the input once it has held long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= RST_VAL;
            cnt_q  <= '0;
        end else if (d == filt_q) begin
            cnt_q  <= '0;
        end else if (cnt_q == LAST) begin
            filt_q <= d;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign q = filt_q;

endmodule

// File: rtl/hb_mode_ctrl.sv
// Module: keeps the register-control command and the register-control flag.
// Assumes pins are already synchronized/filtered; a pin change beats a write.
module hb_mode_ctrl
    import hb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    dis_f,
    input  logic    pwm_s,
    input  logic    dir_s,
    input  logic    cfg_wr,
    input  logic    cfg_spi_mode,
    input  logic    cfg_enable,
    input  logic    cfg_dir,
    input  logic    cfg_pwm,
    output logic    spi_mode,
    output hb_cmd_t reg_cmd
);

    localparam logic [2:0] PINS_RST = 3'b100;

    logic [2:0] pins_now;
    logic [2:0] pins_prev_q;
    logic       pin_chg;
    logic       mode_q;
    hb_cmd_t    cmd_q;

    assign pins_now = {dis_f, pwm_s, dir_s};
    assign pin_chg  = (pins_now != pins_prev_q);

    // Remember the pin levels seen last cycle to detect any change.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_prev_q <= PINS_RST;
        else        pins_prev_q <= pins_now;
    end

    // Register-control flag: set only with all pins low, dropped on any pin change.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= 1'b0;
        else if (pin_chg) mode_q <= 1'b0;
        else if (cfg_wr) mode_q <= cfg_spi_mode && (pins_now == 3'b000);
    end

    // Store the commanded enable, direction and PWM on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cfg_wr) cmd_q <= '{en: cfg_enable, dir: cfg_dir, pwm: cfg_pwm};
    end

    assign spi_mode = mode_q;
    assign reg_cmd  = cmd_q;

endmodule

// File: rtl/hb_switch_decode.sv
// Module: picks the command source, applies the truth table and the
// protection overrides, and registers the four switch enables.
// Assumes protection requests are synchronous to clk.
module hb_switch_decode
    import hb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    spi_mode,
    input  hb_cmd_t reg_cmd,
    input  hb_cmd_t pin_cmd,
    input  logic    chop_hs1,
    input  logic    chop_hs2,
    input  logic    fault_off,
    output hb_sw_t  sw
);

    hb_cmd_t eff_cmd;
    hb_sw_t  sw_nxt;
    hb_sw_t  sw_q;

    // Select the command, decode it and apply the override masks.
    always_comb begin
        eff_cmd = spi_mode ? reg_cmd : pin_cmd;
        sw_nxt  = hb_truth(eff_cmd);
        if (chop_hs1)  sw_nxt.ls2 = 1'b0;
        if (chop_hs2)  sw_nxt.ls1 = 1'b0;
        if (fault_off) sw_nxt     = SW_ALL_OFF;
    end

    // Output register for the switch enables.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= SW_ALL_OFF;
        else        sw_q <= sw_nxt;
    end

    assign sw = sw_q;

endmodule

// File: rtl/hbridge_switch_ctrl.sv
// Module: top of the H-bridge switch control decoder.
// Assumes asynchronous pins and synchronous write/protection inputs.
module hbridge_switch_ctrl
    import hb_pkg::*;
#(
    parameter int FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_dis,
    input  logic pin_pwm,
    input  logic pin_dir,
    input  logic cfg_wr,
    input  logic cfg_spi_mode,
    input  logic cfg_enable,
    input  logic cfg_dir,
    input  logic cfg_pwm,
    input  logic chop_hs1,
    input  logic chop_hs2,
    input  logic fault_off,
    output logic hs1_on,
    output logic ls1_on,
    output logic hs2_on,
    output logic ls2_on,
    output logic spi_mode_o
);

    localparam logic [2:0] PIN_RST = 3'b100;

    logic [2:0] pins_sync;
    logic       dis_s;
    logic       pwm_s;
    logic       dir_s;
    logic       dis_filt;
    logic       spi_mode;
    hb_cmd_t    reg_cmd;
    hb_cmd_t    pin_cmd;
    hb_sw_t     sw;

    hb_pin_sync #(.W(3), .RST_VAL(PIN_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({pin_dis, pin_pwm, pin_dir}),
        .q_sync  (pins_sync)
    );

    assign dis_s = pins_sync[2];
    assign pwm_s = pins_sync[1];
    assign dir_s = pins_sync[0];

    hb_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_dis_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dis_s),
        .q     (dis_filt)
    );

    hb_mode_ctrl u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .dis_f        (dis_filt),
        .pwm_s        (pwm_s),
        .dir_s        (dir_s),
        .cfg_wr       (cfg_wr),
        .cfg_spi_mode (cfg_spi_mode),
        .cfg_enable   (cfg_enable),
        .cfg_dir      (cfg_dir),
        .cfg_pwm      (cfg_pwm),
        .spi_mode     (spi_mode),
        .reg_cmd      (reg_cmd)
    );

    assign pin_cmd = '{en: !dis_filt, dir: dir_s, pwm: pwm_s};

    hb_switch_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_mode  (spi_mode),
        .reg_cmd   (reg_cmd),
        .pin_cmd   (pin_cmd),
        .chop_hs1  (chop_hs1),
        .chop_hs2  (chop_hs2),
        .fault_off (fault_off),
        .sw        (sw)
    );

    assign hs1_on     = sw.hs1;
    assign ls1_on     = sw.ls1;
    assign hs2_on     = sw.hs2;
    assign ls2_on     = sw.ls2;
    assign spi_mode_o = spi_mode;

endmodule

// File: rtl/hb_ctrl_checker.sv
// Module: property checker for hbridge_switch_ctrl, attached by bind.
// Assumes protection and write inputs are synchronous to clk.
module hb_ctrl_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic cfg_spi_mode,
    input logic chop_hs1,
    input logic chop_hs2,
    input logic fault_off,
    input logic hs1_on,
    input logic ls1_on,
    input logic hs2_on,
    input logic ls2_on,
    input logic spi_mode_o,
    input logic dis_f,
    input logic dis_s,
    input logic pwm_s,
    input logic dir_s
);

    AST_LEG1_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(hs1_on && ls1_on)); // R10
    AST_LEG2_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(hs2_on && ls2_on)); // R10
    AST_DIS_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n) (dis_f && !spi_mode_o) |=> !(hs1_on || ls1_on || hs2_on || ls2_on)); // R1
    AST_MODE_SET_GUARD: assert property (@(posedge clk) disable iff (!rst_n) $rose(spi_mode_o) |-> $past(cfg_wr && cfg_spi_mode && !dis_f && !pwm_s && !dir_s)); // R4
    AST_PIN_CHG_DROP: assert property (@(posedge clk) disable iff (!rst_n) !$stable({dis_f, pwm_s, dir_s}) |=> !spi_mode_o); // R5
    AST_CHOP_LS2_OFF: assert property (@(posedge clk) disable iff (!rst_n) chop_hs1 |=> !ls2_on); // R7
    AST_CHOP_LS1_OFF: assert property (@(posedge clk) disable iff (!rst_n) chop_hs2 |=> !ls1_on); // R7
    AST_FAULT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n) fault_off |=> !(hs1_on || ls1_on || hs2_on || ls2_on)); // R8
    AST_DIS_FILT_SRC: assert property (@(posedge clk) disable iff (!rst_n) $rose(dis_f) |-> $past(dis_s)); // R9

endmodule

bind hbridge_switch_ctrl hb_ctrl_checker u_hb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_spi_mode (cfg_spi_mode),
    .chop_hs1     (chop_hs1),
    .chop_hs2     (chop_hs2),
    .fault_off    (fault_off),
    .hs1_on       (hs1_on),
    .ls1_on       (ls1_on),
    .hs2_on       (hs2_on),
    .ls2_on       (ls2_on),
    .spi_mode_o   (spi_mode_o),
    .dis_f        (dis_filt),
    .dis_s        (dis_s),
    .pwm_s        (pwm_s),
    .dir_s        (dir_s)
);

// File: tb/test_hbridge_switch_ctrl.sv
`timescale 1ns/1ps
// Bench: vector table for the truth table and overrides, then directed tests.
module test_hbridge_switch_ctrl;

    localparam int FILT  = 8;
    localparam int SETTLE = 20;
    localparam int NV    = 10;

    // {dis, pwm, dir, chop1, chop2, fault, tag, hs1, ls1, hs2, ls2}
    localparam logic [13:0] VEC [NV] = '{
        {6'b100000, 4'd1, 4'b0000},
        {6'b011000, 4'd2, 4'b1001},
        {6'b010000, 4'd2, 4'b0110},
        {6'b001000, 4'd3, 4'b1000},
        {6'b000000, 4'd3, 4'b0010},
        {6'b011100, 4'd7, 4'b1000},
        {6'b010010, 4'd7, 4'b0010},
        {6'b011001, 4'd8, 4'b0000},
        {6'b111000, 4'd1, 4'b0000},
        {6'b010100, 4'd7, 4'b0110}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_dis = 1'b1, pin_pwm = 1'b0, pin_dir = 1'b0;
    logic cfg_wr = 1'b0, cfg_spi_mode = 1'b0, cfg_enable = 1'b0, cfg_dir = 1'b0, cfg_pwm = 1'b0;
    logic chop_hs1 = 1'b0, chop_hs2 = 1'b0, fault_off = 1'b0;
    logic hs1_on, ls1_on, hs2_on, ls2_on, spi_mode_o;

    int checks = 0;
    int errors = 0;
    int overlap = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hbridge_switch_ctrl #(.FILT_CYC(FILT)) i_hbridge_switch_ctrl (
        .clk(clk), .rst_n(rst_n),
        .pin_dis(pin_dis), .pin_pwm(pin_pwm), .pin_dir(pin_dir),
        .cfg_wr(cfg_wr), .cfg_spi_mode(cfg_spi_mode), .cfg_enable(cfg_enable),
        .cfg_dir(cfg_dir), .cfg_pwm(cfg_pwm),
        .chop_hs1(chop_hs1), .chop_hs2(chop_hs2), .fault_off(fault_off),
        .hs1_on(hs1_on), .ls1_on(ls1_on), .hs2_on(hs2_on), .ls2_on(ls2_on),
        .spi_mode_o(spi_mode_o)
    );

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd7:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] obs();
        return {hs1_on, ls1_on, hs2_on, ls2_on, spi_mode_o};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pins(input logic d, input logic p, input logic r);
        pin_dis = d; pin_pwm = p; pin_dir = r;
        wait_cyc(SETTLE);
    endtask

    task automatic reg_write(input logic m, input logic e, input logic d, input logic p);
        cfg_wr = 1'b1; cfg_spi_mode = m; cfg_enable = e; cfg_dir = d; cfg_pwm = p;
        @(negedge clk);
        cfg_wr = 1'b0;
        wait_cyc(2);
    endtask

    // Leg overlap monitor for R10.
    always @(negedge clk) begin
        if (rst_n && ((hs1_on && ls1_on) || (hs2_on && ls2_on))) overlap++;
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seen;
        wait_cyc(3);
        check("R11 in reset", obs(), 5'b00000);
        @(negedge clk) rst_n = 1'b1;
        check("R11 after reset", obs(), 5'b00000);

        for (int i = 0; i < NV; i++) begin
            chop_hs1  = VEC[i][10];
            chop_hs2  = VEC[i][9];
            fault_off = VEC[i][8];
            set_pins(VEC[i][13], VEC[i][12], VEC[i][11]);
            check(tag_name(VEC[i][7:4]), obs(), {VEC[i][3:0], 1'b0});
        end
        chop_hs1 = 1'b0; chop_hs2 = 1'b0; fault_off = 1'b0;

        // R8: fault acts on the next edge.
        set_pins(1'b0, 1'b1, 1'b1);
        fault_off = 1'b1;
        @(negedge clk);
        check("R8 next edge", obs(), 5'b00000);
        fault_off = 1'b0;
        wait_cyc(2);

        // R4: write refused while PWM pin high.
        set_pins(1'b0, 1'b1, 1'b0);
        reg_write(1'b1, 1'b1, 1'b1, 1'b1);
        check("R4 refused pwm", obs(), 5'b01100);

        // R4/R6: accepted with all pins low, register command drives bridge.
        set_pins(1'b0, 1'b0, 1'b0);
        reg_write(1'b1, 1'b1, 1'b1, 1'b1);
        check("R4 R6 forward", obs(), 5'b10011);
        reg_write(1'b1, 1'b1, 1'b0, 1'b0);
        check("R6 freewheel", obs(), 5'b00101);
        reg_write(1'b1, 1'b0, 1'b1, 1'b1);
        check("R6 disabled", obs(), 5'b00001);
        reg_write(1'b1, 1'b1, 1'b0, 1'b1);
        check("R6 reverse", obs(), 5'b01101);
        fault_off = 1'b1;
        wait_cyc(2);
        check("R8 in reg mode", obs(), 5'b00001);
        fault_off = 1'b0;
        wait_cyc(2);

        // R5: direction pin change drops register control.
        set_pins(1'b0, 1'b0, 1'b1);
        check("R5 dir change", obs(), 5'b10000);

        // R4: refused while disable high.
        set_pins(1'b1, 1'b0, 1'b0);
        reg_write(1'b1, 1'b1, 1'b1, 1'b1);
        check("R4 refused dis", obs(), 5'b00000);

        // R5: disable change drops register control.
        set_pins(1'b0, 1'b0, 1'b0);
        reg_write(1'b1, 1'b1, 1'b1, 1'b1);
        check("R5 setup", obs(), 5'b10011);
        pin_dis = 1'b1;
        wait_cyc(SETTLE);
        check("R5 dis change", obs(), 5'b00000);

        // R9: short disable pulse ignored.
        set_pins(1'b0, 1'b1, 1'b1);
        pin_dis = 1'b1;
        wait_cyc(FILT - 1);
        pin_dis = 1'b0;
        seen = 0;
        for (int k = 0; k < SETTLE; k++) begin
            @(negedge clk);
            if (!hs1_on) seen++;
        end
        check("R9 short pulse", 5'(seen), 5'd0);

        // R9: long disable pulse accepted.
        pin_dis = 1'b1;
        wait_cyc(FILT + 2);
        pin_dis = 1'b0;
        seen = 0;
        for (int k = 0; k < SETTLE; k++) begin
            @(negedge clk);
            if (!hs1_on && !ls2_on) seen++;
        end
        check("R9 long pulse", 5'(seen != 0), 5'd1);
        check("R9 recovered", obs(), 5'b10010);

        check("R10 leg overlap", 5'(overlap), 5'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule